// File: doc/BRIEF.md
# Infrared Pulse-Length Controller

This block times and measures the pulses of an infrared remote-control link. One 8-bit down-counter does both jobs. In transmit mode, software writes a level for the output pin and a length in prescaler ticks. The counter counts that length down. When it reaches zero it raises an underflow cause, so software can load the next pulse. In receive mode, the input pin is synchronised and then sampled on the same prescaler tick. A two-sample filter drops glitches, and rising and falling edges raise separate causes. Software reloads the counter at each edge to measure the width of the pulse that follows.

Two state machines hold the control. The length counter machine has the states `CNT_IDLE` (the count holds zero) and `CNT_RUN` (the count is non-zero):
- A load of a non-zero value moves `CNT_IDLE` to `CNT_RUN`, and also `CNT_RUN` to `CNT_RUN`.
- In `CNT_RUN`, an enabled tick that takes the count from 1 to 0 returns the machine to `CNT_IDLE`.
- A load of zero also returns `CNT_RUN` to `CNT_IDLE`.

The noise filter has the states `FLT_STABLE` (the sample agrees with the filtered level) and `FLT_PEND` (one sample of a new level has been seen):
- A differing sample moves `FLT_STABLE` to `FLT_PEND`.
- A second differing sample moves `FLT_PEND` back to `FLT_STABLE`, updates the level and reports the edge.
- A sample that agrees with the filtered level returns `FLT_PEND` to `FLT_STABLE` with no edge.

Register map (2-bit address):
- 0, control: bit0 enable, bit1 mode (1 = receive, 0 = transmit), bit2 transmit data level.
- 1, interrupt enables: bit0 underflow, bit1 rising, bit2 falling.
- 2, causes: same bit positions as address 1, each write-1-to-clear. Bit4 is the read-only filtered input level.
- 3, length counter: read returns the live count, write loads it.

Top module: `irpl_ctrl`

## Requirements
- R1: While enable is 1, each `tick` pulse decrements the length counter (address 3) by one. A write to address 3 loads the written value.
- R2: An enabled tick that takes the count from 1 to 0 sets cause bit0 (address 2). `irq` rises only if enable bit0 at address 1 is set.
- R3: Once the count is 0 it holds 0 under further ticks, and no further underflow cause is raised until a new value is written.
- R4: A write to address 3 while the count is running replaces the count in that same cycle. The next tick decrements from the new value.
- R5: While enable is 0, ticks leave the count unchanged and `ir_out` is 0.
- R6: With enable 1 and mode 0, `ir_out` equals control bit2. With mode 1, `ir_out` is 0.
- R7: In receive mode, the filtered level changes only when the synchronised input shows the new level on two consecutive ticks. A level seen on one tick only raises no cause.
- R8: A filtered rise sets cause bit1 and a filtered fall sets cause bit2. `irq` is the OR of every cause whose enable bit is set.
- R9: Writing 1 to a cause bit clears only that bit. Writing 0 leaves it unchanged.
- R10: Address 2 bit4 reads the filtered input level. The input passes through a two-flop synchronizer before filtering.
- R11: In transmit mode, input changes raise no edge causes and leave the filtered level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle prescaler tick pulse |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ir_in | input | 1 | Asynchronous receive pin |
| ir_out | output | 1 | Transmit data level |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that:
- the count steps down by exactly one per enabled tick and stays at zero once there;
- the count is frozen while the block is disabled;
- no edge is reported unless a prior sample was pending;
- rising and falling edges are never reported together;
- every underflow lands in its cause bit.

Only the bench scenarios can show the rest, because each depends on a chosen sequence of register writes and pin changes:
- a one-tick glitch is rejected;
- reload takes effect mid-count;
- each enable masks `irq`;
- write-1-to-clear clears single bits;
- transmit mode ignores the input.

// File: rtl/irpl_pkg.sv
package irpl_pkg;
    localparam int CNT_W  = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_IEN  = 2'd1;
    localparam logic [ADDR_W-1:0] A_FLG  = 2'd2;
    localparam logic [ADDR_W-1:0] A_CNT  = 2'd3;

    localparam int B_UF   = 0;
    localparam int B_RISE = 1;
    localparam int B_FALL = 2;

    typedef enum logic {CNT_IDLE, CNT_RUN} cnt_state_t;
    typedef enum logic {FLT_STABLE, FLT_PEND} flt_state_t;
endpackage

// File: rtl/irpl_sync.sv
module irpl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d_i};
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/irpl_filter.sv
module irpl_filter
    import irpl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    input  logic samp_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    flt_state_t state_q, state_d;
    logic       lvl_q, lvl_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_STABLE;
            lvl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
        end
    end

    always_comb begin
        state_d = state_q;
        lvl_d   = lvl_q;
        rise_o  = 1'b0;
        fall_o  = 1'b0;
        if (!en_i) begin
            state_d = FLT_STABLE;
        end else if (tick_i) begin
            unique case (state_q)
                FLT_STABLE: if (samp_i != lvl_q) state_d = FLT_PEND;
                FLT_PEND: begin
                    state_d = FLT_STABLE;
                    if (samp_i != lvl_q) begin
                        lvl_d  = samp_i;
                        rise_o = samp_i;
                        fall_o = !samp_i;
                    end
                end
                default: state_d = FLT_STABLE;
            endcase
        end
    end

    assign lvl_o = lvl_q;

    // R7: an edge is only reported after a pending first sample
    p_two_samples_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o || fall_o) |-> (state_q == FLT_PEND));
    // R8: rising and falling are never reported together
    p_one_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_o, fall_o}));
endmodule

// File: rtl/irpl_counter.sv
module irpl_counter
    import irpl_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] cnt_o,
    output logic         uf_o
);
    cnt_state_t   state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        uf_o    = 1'b0;
        if (load_i) begin
            cnt_d   = load_val_i;
            state_d = (load_val_i != '0) ? CNT_RUN : CNT_IDLE;
        end else begin
            unique case (state_q)
                CNT_IDLE: cnt_d = '0;
                CNT_RUN: if (en_i && tick_i) begin
                    cnt_d = cnt_q - W'(1);
                    if (cnt_q == W'(1)) begin
                        uf_o    = 1'b1;
                        state_d = CNT_IDLE;
                    end
                end
                default: state_d = CNT_IDLE;
            endcase
        end
    end

    assign cnt_o = cnt_q;

    p_dec_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tick_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));
    p_hold_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
    p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/irpl_ctrl.sv
module irpl_ctrl
    import irpl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              ir_in,
    output logic              ir_out,
    output logic              irq
);
    logic [2:0]       ctrl_q, ien_q, flg_q, flg_d, clr_mask;
    logic             en, rx_mode, sync_in, lvl, rise, fall, uf, cnt_load;
    logic [CNT_W-1:0] cnt;

    assign en       = ctrl_q[0];
    assign rx_mode  = ctrl_q[1];
    assign cnt_load = bus_wr && (bus_addr == A_CNT);
    assign clr_mask = (bus_wr && bus_addr == A_FLG) ? bus_wdata[2:0] : 3'b000;

    irpl_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(ir_in), .q_o(sync_in)
    );

    irpl_filter u_filter (
        .clk(clk), .rst_n(rst_n), .en_i(en && rx_mode), .tick_i(tick),
        .samp_i(sync_in), .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    irpl_counter #(.W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .en_i(en), .tick_i(tick),
        .load_i(cnt_load), .load_val_i(bus_wdata[CNT_W-1:0]),
        .cnt_o(cnt), .uf_o(uf)
    );

    always_comb begin
        flg_d = flg_q & ~clr_mask;
        if (uf)   flg_d[B_UF]   = 1'b1;
        if (rise) flg_d[B_RISE] = 1'b1;
        if (fall) flg_d[B_FALL] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ien_q  <= '0;
            flg_q  <= '0;
        end else begin
            if (bus_wr && bus_addr == A_CTRL) ctrl_q <= bus_wdata[2:0];
            if (bus_wr && bus_addr == A_IEN)  ien_q  <= bus_wdata[2:0];
            flg_q <= flg_d;
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = {5'b0, ctrl_q};
            A_IEN:   bus_rdata = {5'b0, ien_q};
            A_FLG:   bus_rdata = {3'b0, lvl, 1'b0, flg_q};
            default: bus_rdata = cnt;
        endcase
    end

    assign ir_out = en && !rx_mode && ctrl_q[2];
    assign irq    = |(flg_q & ien_q);

    p_uf_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        uf |=> flg_q[B_UF]);
    p_tx_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!ir_out || $past(bus_wr && bus_addr == A_CTRL)));
endmodule

// File: tb/irpl_ctrl_test.sv
module irpl_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ir_in = 1'b0;
    logic       ir_out, irq;
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    irpl_ctrl uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ir_in(ir_in), .ir_out(ir_out), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk); ir_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        int v;
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v); chk("R1 reset reg", v, 0);
        end
        chk("R5 reset ir_out", ir_out, 0);
        chk("R8 reset irq", irq, 0);
    endtask

    task automatic t_underflow();
        int v;
        wr(3, 8'd3); wr(0, 8'h01);
        pulse_tick(2);
        rd(3, v); chk("R1 count after 2 ticks", v, 1);
        rd(2, v); chk("R2 no flag before zero", v, 0);
        pulse_tick(1);
        rd(3, v); chk("R2 count zero", v, 0);
        rd(2, v); chk("R2 underflow flag", v, 1);
        chk("R2 irq masked", irq, 0);
        wr(1, 8'h01);
        chk("R2 irq enabled", irq, 1);
        wr(2, 8'h01);
        rd(2, v); chk("R9 uf cleared", v, 0);
        pulse_tick(3);
        rd(3, v); chk("R3 holds zero", v, 0);
        rd(2, v); chk("R3 no new underflow", v, 0);
        wr(1, 8'h00);
    endtask

    task automatic t_reload();
        int v;
        wr(3, 8'd5); pulse_tick(1);
        rd(3, v); chk("R1 5 to 4", v, 4);
        wr(3, 8'd9);
        rd(3, v); chk("R4 reload value", v, 9);
        pulse_tick(1);
        rd(3, v); chk("R4 decrement from reload", v, 8);
    endtask

    task automatic t_disable_tx();
        int v;
        wr(0, 8'h04);
        pulse_tick(3);
        rd(3, v); chk("R5 frozen count", v, 8);
        chk("R5 ir_out low when disabled", ir_out, 0);
        wr(0, 8'h05);
        chk("R6 ir_out follows data 1", ir_out, 1);
        wr(0, 8'h01);
        chk("R6 ir_out follows data 0", ir_out, 0);
        wr(0, 8'h07);
        chk("R6 ir_out low in receive", ir_out, 0);
    endtask

    task automatic t_receive();
        int v;
        wr(0, 8'h03); wr(3, 8'hff); wr(1, 8'h02);
        set_pin(1'b1); pulse_tick(1);
        set_pin(1'b0); pulse_tick(1);
        rd(2, v); chk("R7 glitch rejected", v, 0);
        set_pin(1'b1); pulse_tick(1);
        rd(2, v); chk("R7 one sample no edge", v, 0);
        pulse_tick(1);
        rd(2, v); chk("R8 rise flag and R10 level", v, 8'h12);
        chk("R8 irq rise enabled", irq, 1);
        wr(1, 8'h04);
        chk("R8 irq rise masked", irq, 0);
        set_pin(1'b0); pulse_tick(2);
        rd(2, v); chk("R8 fall flag", v, 8'h06);
        chk("R8 irq fall enabled", irq, 1);
        wr(2, 8'h02);
        rd(2, v); chk("R9 clears rise only", v, 8'h04);
        wr(2, 8'h00);
        rd(2, v); chk("R9 write 0 no effect", v, 8'h04);
        wr(2, 8'h04);
        rd(2, v); chk("R9 clears fall", v, 0);
        wr(1, 8'h00);
    endtask

    task automatic t_tx_ignores_input();
        int v;
        wr(0, 8'h01);
        set_pin(1'b1); pulse_tick(3);
        rd(2, v); chk("R11 no edge in transmit", v, 0);
        set_pin(1'b0); pulse_tick(3);
        rd(2, v); chk("R11 still no edge", v, 0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_underflow();
        t_reload();
        t_disable_tx();
        t_receive();
        t_tx_ignores_input();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule